// File: doc/BRIEF.md
# Accumulator Arithmetic and Rotate Unit

This block is the execution stage of a small 8-bit accumulator machine. In one clock cycle it can do any of the following:

- apply one of eight accumulator operations to the accumulator and an operand byte;
- rotate the accumulator in one of four ways;
- step a general register up or down by one.

The operand byte comes from the register file or from an immediate field. The block keeps a registered set of four flags: carry, zero, sign and parity. Its registered result comes with a one-cycle write pulse for the destination register.

The surrounding sequencer presents the accumulator, the operand, a 2-bit operation class, a 3-bit function code and a start strobe. One clock edge later it reads the result, the write pulse and the updated flags. For increment and decrement, the register to be stepped is presented on the operand input. Operand fetch, register storage and sequencing sit outside the block.

Top module: `acc_alu_unit`

## Requirements
- R1: With class 00, function codes 000 add, 001 add-with-carry, 010 subtract and 011 subtract-with-borrow compute on the accumulator and operand modulo 256. Carry is set on carry out for the adds, and on borrow for the subtracts.
- R2: With class 00, function codes 100 AND, 110 OR and 101 XOR give the bitwise result and clear carry.
- R3: With class 00, function 111 (compare) sets the flags from accumulator minus operand, with carry on borrow. It leaves the write pulse low and the result output unchanged.
- R4: With class 01, fn[1:0]=00 rotates left with old bit 7 into bit 0 and carry. fn[1:0]=01 rotates right with old bit 0 into bit 7 and carry.
- R5: With class 01, fn[1:0]=10 rotates left with old carry into bit 0 and old bit 7 into carry. fn[1:0]=11 rotates right with old carry into bit 7 and old bit 0 into carry.
- R6: A rotate changes only the carry flag; zero, sign and parity keep their values.
- R7: Class 10 produces operand plus one and class 11 produces operand minus one, both modulo 256. Neither changes carry.
- R8: For every operation other than a rotate, zero is set for a zero value, sign copies value bit 7, and parity is set for an even count of ones. Compare evaluates these on the difference.
- R9: While the strobe is low, the result and flags hold and the write pulse is low.
- R10: After reset, the result is 0x00, all four flags are 0 and the write pulse is low.
- R11: The result and flags of a strobed operation appear after the next rising clock edge. The write pulse is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Executes the presented operation at this edge |
| op_class | input | 2 | 00 ALU, 01 rotate, 10 increment, 11 decrement |
| fn_sel | input | 3 | ALU function code, or rotate kind in bits [1:0] |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Operand byte: register, immediate, or register to step |
| result_q | output | 8 | Registered result |
| wr_en_q | output | 1 | One-cycle write strobe for the destination |
| flag_cy | output | 1 | Carry / borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_p | output | 1 | Even-parity flag |

## Verification
A wrong carry flag in this block shows up at the ports on the next add-with-carry, subtract-with-borrow or through-carry rotate, one cycle after that strobe. It would otherwise stay hidden, so the bench chains such operations directly behind the ones that set or clear carry. A wrong zero, sign or parity state after a rotate only shows if the flag outputs are compared right after the rotate, so each rotate is checked against the flags held from the previous operation. A result or write pulse that leaks through compare or an idle cycle appears within one cycle on `result_q` and `wr_en_q`.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   typedef enum logic [1:0] {
      CLS_ALU = 2'b00,
      CLS_ROT = 2'b01,
      CLS_INC = 2'b10,
      CLS_DEC = 2'b11
   } op_class_e;

   localparam logic [2:0] FN_ADD = 3'd0;
   localparam logic [2:0] FN_ADC = 3'd1;
   localparam logic [2:0] FN_SUB = 3'd2;
   localparam logic [2:0] FN_SBB = 3'd3;
   localparam logic [2:0] FN_AND = 3'd4;
   localparam logic [2:0] FN_XOR = 3'd5;
   localparam logic [2:0] FN_OR  = 3'd6;
   localparam logic [2:0] FN_CMP = 3'd7;

   localparam logic [1:0] ROT_LC = 2'd0;
   localparam logic [1:0] ROT_RC = 2'd1;
   localparam logic [1:0] ROT_LT = 2'd2;
   localparam logic [1:0] ROT_RT = 2'd3;

   typedef struct packed {
      logic cy;
      logic z;
      logic s;
      logic p;
   } flags_t;
endpackage

// File: rtl/alu_arith.sv
module alu_arith
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [2:0]   fn,
   input  logic         cy_in,
   output logic [W-1:0] res,
   output logic         cy_out
);
   localparam int EW = W + 1;

   logic [EW-1:0] ext_a, ext_b, ext_c, wide;

   assign ext_a = {1'b0, a};
   assign ext_b = {1'b0, b};
   assign ext_c = {{W{1'b0}}, cy_in};

   always_comb begin
      case (fn)
         FN_ADD:  wide = ext_a + ext_b;
         FN_ADC:  wide = ext_a + ext_b + ext_c;
         FN_SUB:  wide = ext_a - ext_b;
         FN_SBB:  wide = ext_a - ext_b - ext_c;
         FN_AND:  wide = {1'b0, a & b};
         FN_XOR:  wide = {1'b0, a ^ b};
         FN_OR:   wide = {1'b0, a | b};
         default: wide = ext_a - ext_b;
      endcase
   end

   assign res    = wide[W-1:0];
   assign cy_out = wide[W];

   // R2
   logic_clr_chk: assert final ((fn < FN_AND) || (fn == FN_CMP) || !cy_out);
endmodule

// File: rtl/alu_rotor.sv
module alu_rotor
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic         cy_in,
   input  logic [1:0]   kind,
   output logic [W-1:0] res,
   output logic         cy_out
);
   logic [W-1:0] up_sh, dn_sh;
   logic         fill_lo, fill_hi;

   assign fill_lo = (kind == ROT_LC) ? a[W-1] : cy_in;
   assign fill_hi = (kind == ROT_RC) ? a[0]   : cy_in;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (i == 0) begin : g_lo
            assign up_sh[i] = fill_lo;
            assign dn_sh[i] = a[i+1];
         end else if (i == W - 1) begin : g_hi
            assign up_sh[i] = a[i-1];
            assign dn_sh[i] = fill_hi;
         end else begin : g_mid
            assign up_sh[i] = a[i-1];
            assign dn_sh[i] = a[i+1];
         end
      end
   endgenerate

   assign res    = kind[0] ? dn_sh : up_sh;
   assign cy_out = kind[0] ? a[0]  : a[W-1];

   // R4
   circ_cy_chk: assert final (kind[1] || (kind[0] ? (res[W-1] == cy_out) : (res[0] == cy_out)));
endmodule

// File: rtl/alu_stepper.sv
module alu_stepper #(
   parameter int W = 8
) (
   input  logic [W-1:0] v,
   input  logic         down,
   output logic [W-1:0] res
);
   logic [W-1:0] delta;

   assign delta = down ? {W{1'b1}} : {{(W-1){1'b0}}, 1'b1};
   assign res   = v + delta;
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
   import acc_alu_pkg::*;
#(
   parameter int W            = 8,
   parameter bit PARITY_EVEN  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [1:0]   op_class,
   input  logic [2:0]   fn_sel,
   input  logic [W-1:0] acc_in,
   input  logic [W-1:0] opnd_in,
   output logic [W-1:0] result_q,
   output logic         wr_en_q,
   output logic         flag_cy,
   output logic         flag_z,
   output logic         flag_s,
   output logic         flag_p
);
   localparam int MSB = W - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("acc_alu_unit: W must be at least 2");
      end
   endgenerate

   op_class_e    cls;
   flags_t       fl_q, fl_d;
   logic [W-1:0] ar_res, rot_res, st_res, val, res_d;
   logic         ar_cy, rot_cy, wr_d, par_bit, is_cmp;

   assign cls    = op_class_e'(op_class);
   assign is_cmp = (cls == CLS_ALU) && (fn_sel == FN_CMP);

   alu_arith #(.W(W)) u_arith (
      .a(acc_in), .b(opnd_in), .fn(fn_sel), .cy_in(fl_q.cy),
      .res(ar_res), .cy_out(ar_cy)
   );

   alu_rotor #(.W(W)) u_rotor (
      .a(acc_in), .cy_in(fl_q.cy), .kind(fn_sel[1:0]),
      .res(rot_res), .cy_out(rot_cy)
   );

   alu_stepper #(.W(W)) u_step (
      .v(opnd_in), .down(cls == CLS_DEC), .res(st_res)
   );

   assign val = (cls == CLS_ALU) ? ar_res : st_res;

   generate
      if (PARITY_EVEN) begin : g_par_even
         assign par_bit = ~^val;
      end else begin : g_par_odd
         assign par_bit = ^val;
      end
   endgenerate

   always_comb begin
      fl_d  = fl_q;
      res_d = result_q;
      wr_d  = 1'b1;
      case (cls)
         CLS_ALU: begin
            fl_d.cy = ar_cy;
            if (is_cmp) wr_d = 1'b0;
            else        res_d = ar_res;
         end
         CLS_ROT: begin
            fl_d.cy = rot_cy;
            res_d   = rot_res;
         end
         default: res_d = st_res;
      endcase
      if (cls != CLS_ROT) begin
         fl_d.z = (val == '0);
         fl_d.s = val[MSB];
         fl_d.p = par_bit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_q <= '0;
         wr_en_q  <= 1'b0;
         fl_q     <= '0;
      end else if (start) begin
         result_q <= res_d;
         wr_en_q  <= wr_d;
         fl_q     <= fl_d;
      end else begin
         wr_en_q  <= 1'b0;
      end
   end

   assign flag_cy = fl_q.cy;
   assign flag_z  = fl_q.z;
   assign flag_s  = fl_q.s;
   assign flag_p  = fl_q.p;

   // R3
   cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_class == 2'b00 && fn_sel == 3'd7) |=> (!wr_en_q && $stable(result_q)));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (!wr_en_q && $stable(result_q) && $stable(fl_q)));

   // R6
   rot_keep_zsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_class == 2'b01) |=> ($stable(flag_z) && $stable(flag_s) && $stable(flag_p)));

   // R7
   step_keep_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_class[1]) |=> $stable(flag_cy));

   // R8
   zero_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (op_class[1] || (op_class == 2'b00 && fn_sel != 3'd7))) |=> (flag_z == (result_q == '0)));

   // R2
   logic_cy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_class == 2'b00 && fn_sel[2] && fn_sel != 3'd7) |=> !flag_cy);

   // R11
   write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !(op_class == 2'b00 && fn_sel == 3'd7)) |=> wr_en_q);
endmodule

// File: tb/acc_alu_unit_bench.sv
module acc_alu_unit_bench;
   localparam int PERIOD = 10;
   localparam int NV     = 22;

   // {class, fn, acc, operand}
   localparam logic [20:0] VEC [NV] = '{
      {2'b00, 3'd0, 8'h3C, 8'h0F},
      {2'b00, 3'd0, 8'hFF, 8'h01},
      {2'b00, 3'd1, 8'h10, 8'h20},
      {2'b00, 3'd2, 8'h05, 8'h07},
      {2'b00, 3'd3, 8'h10, 8'h01},
      {2'b00, 3'd4, 8'hF0, 8'h3C},
      {2'b00, 3'd5, 8'hAA, 8'hAA},
      {2'b00, 3'd6, 8'h80, 8'h01},
      {2'b00, 3'd7, 8'h20, 8'h30},
      {2'b00, 3'd7, 8'h44, 8'h44},
      {2'b01, 3'd0, 8'h81, 8'h00},
      {2'b01, 3'd1, 8'h81, 8'h00},
      {2'b01, 3'd2, 8'h40, 8'h00},
      {2'b01, 3'd3, 8'h02, 8'h00},
      {2'b01, 3'd2, 8'h80, 8'h00},
      {2'b01, 3'd7, 8'h01, 8'h00},
      {2'b10, 3'd0, 8'h00, 8'h7F},
      {2'b10, 3'd0, 8'h00, 8'hFF},
      {2'b11, 3'd0, 8'h00, 8'h00},
      {2'b11, 3'd0, 8'h00, 8'h01},
      {2'b00, 3'd3, 8'h00, 8'h00},
      {2'b00, 3'd1, 8'hFF, 8'h00}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] op_class = '0;
   logic [2:0] fn_sel = '0;
   logic [7:0] acc_in = '0, opnd_in = '0;
   logic [7:0] result_q;
   logic       wr_en_q, flag_cy, flag_z, flag_s, flag_p;

   int  errors = 0, checks = 0;
   bit  done = 1'b0;
   logic [7:0] m_res = '0;
   logic m_cy = 0, m_z = 0, m_s = 0, m_p = 0, m_wr = 0;

   always #(PERIOD/2) clk = ~clk;

   acc_alu_unit u_acc_alu_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .op_class(op_class),
      .fn_sel(fn_sel), .acc_in(acc_in), .opnd_in(opnd_in),
      .result_q(result_q), .wr_en_q(wr_en_q), .flag_cy(flag_cy),
      .flag_z(flag_z), .flag_s(flag_s), .flag_p(flag_p)
   );

   task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   function automatic void set_zsp(input int v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += (v >> i) & 1;
      m_z = (v == 0);
      m_s = v[7];
      m_p = (n % 2 == 0);
   endfunction

   function automatic void model(input logic [1:0] c, input logic [2:0] f,
                                 input logic [7:0] a, input logic [7:0] b);
      int ai = a, bi = b, ci = m_cy, t;
      m_wr = 1;
      if (c == 2'b00) begin
         case (f)
            3'd0: t = ai + bi;
            3'd1: t = ai + bi + ci;
            3'd2, 3'd7: t = ai - bi;
            3'd3: t = ai - bi - ci;
            3'd4: t = ai & bi;
            3'd5: t = ai ^ bi;
            default: t = ai | bi;
         endcase
         m_cy = (t > 255) || (t < 0);
         set_zsp(t & 255);
         if (f == 3'd7) m_wr = 0;
         else m_res = 8'(t & 255);
      end else if (c == 2'b01) begin
         case (f[1:0])
            2'd0: begin m_res = {a[6:0], a[7]}; m_cy = a[7]; end
            2'd1: begin m_res = {a[0], a[7:1]}; m_cy = a[0]; end
            2'd2: begin m_res = {a[6:0], m_cy}; m_cy = a[7]; end
            default: begin m_res = {m_cy, a[7:1]}; m_cy = a[0]; end
         endcase
      end else begin
         t = (c == 2'b10) ? (bi + 1) & 255 : (bi + 255) & 255;
         m_res = 8'(t);
         set_zsp(t);
      end
   endfunction

   function automatic string tag_of(input logic [1:0] c, input logic [2:0] f);
      if (c == 2'b00) return (f == 3'd7) ? "R3" : (f[2] ? "R2" : "R1");
      if (c == 2'b01) return f[1] ? "R5" : "R4";
      return "R7";
   endfunction

   task automatic run_op(input logic [1:0] c, input logic [2:0] f,
                         input logic [7:0] a, input logic [7:0] b);
      @(negedge clk);
      op_class = c; fn_sel = f; acc_in = a; opnd_in = b; start = 1'b1;
      model(c, f, a, b);
      @(negedge clk);
      start = 1'b0;
      check({tag_of(c, f), " result/R11 wr"}, {3'b0, result_q, wr_en_q}, {3'b0, m_res, m_wr});
      check(c == 2'b01 ? "R6 flags" : "R8 flags",
            {8'b0, flag_cy, flag_z, flag_s, flag_p}, {8'b0, m_cy, m_z, m_s, m_p});
   endtask

   initial begin
      #(PERIOD * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      check("R10 reset", {3'b0, result_q, wr_en_q}, 12'h000);
      check("R10 flags", {8'b0, flag_cy, flag_z, flag_s, flag_p}, 12'h000);

      for (int k = 0; k < NV; k++)
         run_op(VEC[k][20:19], VEC[k][18:16], VEC[k][15:8], VEC[k][7:0]);

      // R11: write pulse drops after one cycle
      run_op(2'b00, 3'd0, 8'h01, 8'h02);
      @(negedge clk);
      check("R11 pulse width", {11'b0, wr_en_q}, 12'h000);

      // R9: inputs change with start low, nothing moves
      op_class = 2'b01; fn_sel = 3'd0; acc_in = 8'hFF; opnd_in = 8'h55;
      repeat (3) @(negedge clk);
      check("R9 idle result/wr", {3'b0, result_q, wr_en_q}, {3'b0, m_res, 1'b0});
      check("R9 idle flags", {8'b0, flag_cy, flag_z, flag_s, flag_p},
            {8'b0, m_cy, m_z, m_s, m_p});

      // R3: back-to-back compares keep result
      run_op(2'b00, 3'd7, 8'h00, 8'h01);
      run_op(2'b00, 3'd7, 8'h80, 8'h00);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule